// File: doc/BRIEF.md
# Pin I/O Hub with Per-Pin Interrupt Triggers

This block is a bus-mapped general-purpose pin controller. It serves one narrow port whose pins can raise interrupts, plus a set of wider plain ports that only drive and sample pins. Every port offers an output value register, an output-enable register and a read-only view of its pins. External pin inputs are passed through a two-stage synchroniser before anything inside the block looks at them.

On the interrupt port each pin picks its own trigger condition from a 3-bit mode field. A triggered pin raises a pending flag. Software sees pending flags only through a masked status view, and clears them by writing ones to an acknowledge address. One registered interrupt line goes high while any pending pin is also enabled in the mask.

The bus is a single-cycle register interface: a write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the address.

Top module: `pin_io_hub`

## Requirements
- R1: After reset every register reads 0, `pins_out` and `pins_oe` are all 0 (every pin is an input), and `irq` is 0.
- R2: Port p (0 = interrupt port, 1..PLAIN_PORTS = plain ports) has its output value at word address 4p and its output enable at 4p+2. Both can be written and read back. They drive the port's slice of `pins_out` and `pins_oe`, where an enable bit of 1 makes the pin an output. Data bits above the port width are dropped and read as 0.
- R3: Word address 4p+1 returns the port's pins after a two-flop synchroniser. A pin change set up before a clock edge appears in the read only after the second edge.
- R4: Writes to a pin-view address (4p+1) or to the masked status address change no register.
- R5: Mode 1 (high level) sets a pin's pending flag on every cycle the pin is 1, so an acknowledge while the pin stays 1 does not leave the flag clear.
- R6: Mode 2 (low level) sets pending on every cycle the pin is 0.
- R7: Mode 3 (set) is one-shot. It sets pending on the first cycle the pin is 1 after the mode register was written with 3 for that pin. It does not fire again until that mode is written again.
- R8: Mode 4 sets pending on a 0-to-1 change of the synchronised pin, mode 5 on a 1-to-0 change, and mode 6 on either change.
- R9: Mode codes 0 and 7 never set pending.
- R10: With C = 4*(PLAIN_PORTS+1), address C holds the mode register (3 bits per pin, pin i at bits 3i+2..3i). C+1 is the mask register, and it reads back. C+2 reads pending AND mask.
- R11: A pin whose mask bit is 0 does not drive `irq`, but its pending flag stays set and appears in the status read once the mask bit is set again.
- R12: Writing 1 to bit i at address C+3 clears pending for pin i, and writing 0 leaves it unchanged. A trigger in the same cycle as the acknowledge wins.
- R13: `irq` is registered. It equals the OR of the masked pending bits one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pins_in | input | IRQ_W+PLAIN_PORTS*PLAIN_W | Asynchronous pin inputs, interrupt port in the low bits |
| pins_out | output | IRQ_W+PLAIN_PORTS*PLAIN_W | Pin output values |
| pins_oe | output | IRQ_W+PLAIN_PORTS*PLAIN_W | Pin output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong pending flag becomes visible on the status read in the cycle after the trigger, and on `irq` one cycle after that. So a mode decoding fault or a lost acknowledge appears within three cycles of the pin's synchronised change. A wrong previous-sample register shows up as a missed or doubled edge trigger. A stuck one-shot arming flag shows up as a set-mode pin that re-fires after acknowledge. Mask faults are separated from pending faults by clearing the mask, reading status and `irq`, then setting the mask again and reading the still-pending flag.

// File: rtl/pinhub_pkg.sv
package pinhub_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_SET  = 3'd3,
        TRIG_RISE = 3'd4,
        TRIG_FALL = 3'd5,
        TRIG_ANY  = 3'd6,
        TRIG_RSVD = 3'd7
    } trig_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
        logic armed;
    } pin_view_t;

    localparam int PORT_STRIDE = 4;
    localparam int OFS_DOUT    = 0;
    localparam int OFS_DIN     = 1;
    localparam int OFS_OE      = 2;
    localparam int OFS_MODE    = 0;
    localparam int OFS_MASK    = 1;
    localparam int OFS_STAT    = 2;
    localparam int OFS_ACK     = 3;
    localparam int MODE_BITS   = 3;

    function automatic logic trig_hit(trig_mode_e m, pin_view_t v);
        case (m)
            TRIG_HIGH: trig_hit = v.cur;
            TRIG_LOW:  trig_hit = !v.cur;
            TRIG_SET:  trig_hit = v.cur && v.armed;
            TRIG_RISE: trig_hit = v.cur && !v.prev;
            TRIG_FALL: trig_hit = !v.cur && v.prev;
            TRIG_ANY:  trig_hit = v.cur ^ v.prev;
            default:   trig_hit = 1'b0;
        endcase
    endfunction

    function automatic int ctrl_base(int plain_ports);
        return (plain_ports + 1) * PORT_STRIDE;
    endfunction

endpackage

// File: rtl/pinhub_sync.sv
module pinhub_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            synced <= '0;
        end else begin
            stage1 <= raw;
            synced <= stage1;
        end
    end
endmodule

// File: rtl/pinhub_port.sv
module pinhub_port
    import pinhub_pkg::*;
#(
    parameter int W      = 18,
    parameter int BASE   = 0,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_s,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(BASE + OFS_DOUT);
    localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(BASE + OFS_DIN);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(BASE + OFS_OE);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe   <= '0;
        end else if (wr_en) begin
            if (addr == A_DOUT) dout <= wdata;
            if (addr == A_OE)   oe   <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_DOUT)     rd_data[W-1:0] = dout;
        else if (addr == A_DIN) rd_data[W-1:0] = pin_s;
        else if (addr == A_OE)  rd_data[W-1:0] = oe;
    end
endmodule

// File: rtl/pinhub_irq.sv
module pinhub_irq
    import pinhub_pkg::*;
#(
    parameter int W      = 8,
    parameter int BASE   = 20,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MODE_BITS*W-1:0] wdata,
    input  logic [W-1:0]      pin_s,
    output logic [DATA_W-1:0] rd_data,
    output logic [W-1:0]      pend,
    output logic [W-1:0]      mask,
    output logic              irq
);
    localparam int MW = MODE_BITS * W;
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BASE + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(BASE + OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(BASE + OFS_ACK);

    logic [MW-1:0] mode_q;
    logic [W-1:0]  prev_q, armed_q, armed_d, hit, ack_bits;
    logic          mode_wr, mask_wr, ack_wr;

    assign mode_wr  = wr_en && (addr == A_MODE);
    assign mask_wr  = wr_en && (addr == A_MASK);
    assign ack_wr   = wr_en && (addr == A_ACK);
    assign ack_bits = ack_wr ? wdata[W-1:0] : '0;

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_view_t  view;
        trig_mode_e m_cur, m_new;
        assign view  = '{cur: pin_s[i], prev: prev_q[i], armed: armed_q[i]};
        assign m_cur = trig_mode_e'(mode_q[MODE_BITS*i +: MODE_BITS]);
        assign m_new = trig_mode_e'(wdata[MODE_BITS*i +: MODE_BITS]);
        assign hit[i] = trig_hit(m_cur, view);
        assign armed_d[i] = mode_wr ? (m_new == TRIG_SET)
                                    : (armed_q[i] && !hit[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            mask    <= '0;
            pend    <= '0;
            prev_q  <= '0;
            armed_q <= '0;
            irq     <= 1'b0;
        end else begin
            prev_q  <= pin_s;
            armed_q <= armed_d;
            pend    <= (pend & ~ack_bits) | hit;
            irq     <= |(pend & mask);
            if (mode_wr) mode_q <= wdata;
            if (mask_wr) mask   <= wdata[W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_MODE)      rd_data[MW-1:0] = mode_q;
        else if (addr == A_MASK) rd_data[W-1:0]  = mask;
        else if (addr == A_STAT) rd_data[W-1:0]  = pend & mask;
    end
endmodule

// File: rtl/pin_io_hub.sv
module pin_io_hub
    import pinhub_pkg::*;
#(
    parameter int IRQ_W       = 8,
    parameter int PLAIN_W     = 18,
    parameter int PLAIN_PORTS = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 bus_en,
    input  logic                                 bus_we,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [DATA_W-1:0]                    bus_wdata,
    output logic [DATA_W-1:0]                    bus_rdata,
    input  logic [IRQ_W+PLAIN_PORTS*PLAIN_W-1:0] pins_in,
    output logic [IRQ_W+PLAIN_PORTS*PLAIN_W-1:0] pins_out,
    output logic [IRQ_W+PLAIN_PORTS*PLAIN_W-1:0] pins_oe,
    output logic                                 irq
);
    localparam int PIN_W     = IRQ_W + PLAIN_PORTS * PLAIN_W;
    localparam int NPORTS    = PLAIN_PORTS + 1;
    localparam int CTRL_BASE = ctrl_base(PLAIN_PORTS);

    logic [PIN_W-1:0]  pin_s;
    logic              wr_en;
    logic [DATA_W-1:0] port_rd [NPORTS];
    logic [DATA_W-1:0] irq_rd;
    logic [IRQ_W-1:0]  pend, mask;

    assign wr_en = bus_en && bus_we;

    pinhub_sync #(.W(PIN_W)) u_sync (
        .clk(clk), .rst(rst), .raw(pins_in), .synced(pin_s)
    );

    pinhub_port #(.W(IRQ_W), .BASE(0), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata[IRQ_W-1:0]), .pin_s(pin_s[IRQ_W-1:0]),
        .dout(pins_out[IRQ_W-1:0]), .oe(pins_oe[IRQ_W-1:0]),
        .rd_data(port_rd[0])
    );

    for (genvar k = 0; k < PLAIN_PORTS; k++) begin : g_plain
        localparam int LO = IRQ_W + k * PLAIN_W;
        pinhub_port #(.W(PLAIN_W), .BASE((k + 1) * PORT_STRIDE),
                      .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr),
            .wdata(bus_wdata[PLAIN_W-1:0]), .pin_s(pin_s[LO +: PLAIN_W]),
            .dout(pins_out[LO +: PLAIN_W]), .oe(pins_oe[LO +: PLAIN_W]),
            .rd_data(port_rd[k + 1])
        );
    end

    pinhub_irq #(.W(IRQ_W), .BASE(CTRL_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata[MODE_BITS*IRQ_W-1:0]), .pin_s(pin_s[IRQ_W-1:0]),
        .rd_data(irq_rd), .pend(pend), .mask(mask), .irq(irq)
    );

    always_comb begin
        bus_rdata = irq_rd;
        for (int k = 0; k < NPORTS; k++) bus_rdata |= port_rd[k];
    end
endmodule

// File: rtl/pinhub_chk.sv
module pinhub_chk #(
    parameter int IRQ_W     = 8,
    parameter int PIN_W     = 80,
    parameter int ADDR_W    = 5,
    parameter int CTRL_BASE = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [IRQ_W-1:0]  pend,
    input logic [IRQ_W-1:0]  mask,
    input logic              irq,
    input logic [PIN_W-1:0]  pins_out,
    input logic [PIN_W-1:0]  pins_oe
);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(CTRL_BASE + 3);
    localparam logic [ADDR_W-1:0] DIN0_A = ADDR_W'(1);

    logic ack_write, din_write;
    assign ack_write = bus_en && bus_we && (bus_addr == ACK_A);
    assign din_write = bus_en && bus_we && (bus_addr == DIN0_A);

    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (!irq && pins_oe == '0 && pins_out == '0));

    a_r13_irq_rises: assert property (@(posedge clk) disable iff (rst)
        (|(pend & mask)) |=> irq);

    a_r13_irq_falls: assert property (@(posedge clk) disable iff (rst)
        !(|(pend & mask)) |=> !irq);

    a_r12_pend_holds: assert property (@(posedge clk) disable iff (rst)
        !ack_write |=> ((pend & $past(pend)) == $past(pend)));

    a_r4_din_write_inert: assert property (@(posedge clk) disable iff (rst)
        din_write |=> ($stable(pins_out) && $stable(pins_oe)));
endmodule

bind pin_io_hub pinhub_chk #(
    .IRQ_W(IRQ_W), .PIN_W(PIN_W), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)
) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .pend(pend), .mask(mask), .irq(irq),
    .pins_out(pins_out), .pins_oe(pins_oe)
);

// File: tb/test_pin_io_hub.sv
`timescale 1ns/1ps
module test_pin_io_hub;
    localparam int IRQ_W = 8, PLAIN_W = 18, PLAIN_PORTS = 4;
    localparam int PIN_W = IRQ_W + PLAIN_PORTS * PLAIN_W;
    localparam int C = 4 * (PLAIN_PORTS + 1);
    localparam int NV = 16;
    // {mode[2:0], pin before, pin after, expected pending}
    localparam logic [5:0] VEC [NV] = '{
        {3'd1,3'b000}, {3'd1,3'b111}, {3'd1,3'b011},
        {3'd2,3'b110}, {3'd2,3'b001},
        {3'd3,3'b011}, {3'd3,3'b110},
        {3'd4,3'b011}, {3'd4,3'b100},
        {3'd5,3'b101}, {3'd5,3'b010},
        {3'd6,3'b011}, {3'd6,3'b101}, {3'd6,3'b110},
        {3'd0,3'b010}, {3'd7,3'b100}
    };

    logic clk = 0, rst = 1, bus_en = 0, bus_we = 0, irq;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rd;
    logic [PIN_W-1:0] pins_in = '0, pins_out, pins_oe;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    pin_io_hub i_pin_io_hub (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rdreg(int a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 5'(a);
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    function automatic string tag_of(logic [2:0] m);
        case (m)
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4, 3'd5, 3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state
        rdreg(0, rd);      check("R1 dout0", rd, 0);
        rdreg(2, rd);      check("R1 oe0", rd, 0);
        rdreg(C, rd);      check("R1 mode", rd, 0);
        rdreg(C + 1, rd);  check("R1 mask", rd, 0);
        rdreg(C + 2, rd);  check("R1 stat", rd, 0);
        check("R1 pins_oe", 32'(pins_oe != '0), 0);
        check("R1 irq", 32'(irq), 0);

        // R2: output value and enable registers
        wr(4, 32'hFFFF_FFFF);
        rdreg(4, rd);      check("R2 dout1 width", rd, 32'h3FFFF);
        check("R2 pins_out1", 32'(pins_out[IRQ_W +: PLAIN_W]), 32'h3FFFF);
        wr(6, 32'h155);
        rdreg(6, rd);      check("R2 oe1", rd, 32'h155);
        check("R2 pins_oe1", 32'(pins_oe[IRQ_W +: PLAIN_W]), 32'h155);
        wr(0, 32'h1A5);
        rdreg(0, rd);      check("R2 dout0", rd, 32'hA5);
        check("R2 pins_out0", 32'(pins_out[7:0]), 32'hA5);

        // R3: two-flop synchroniser latency on port 1 bit 3
        @(negedge clk);
        pins_in[IRQ_W + 3] = 1'b1;
        bus_en = 1; bus_we = 0; bus_addr = 5'd5;
        @(posedge clk); #1 check("R3 after one edge", bus_rdata, 0);
        @(posedge clk); #1 check("R3 after two edges", bus_rdata, 32'h8);
        bus_en = 0;

        // R4: writes to pin view and status are inert
        wr(5, 32'hFFFF_FFFF);
        rdreg(4, rd);      check("R4 dout1 kept", rd, 32'h3FFFF);
        rdreg(6, rd);      check("R4 oe1 kept", rd, 32'h155);
        rdreg(5, rd);      check("R4 din1 is pins", rd, 32'h8);
        wr(C + 2, 32'hFF);
        rdreg(C + 1, rd);  check("R4 mask kept", rd, 0);

        // vector table: trigger modes R5..R9, status via mask R10
        wr(C + 1, 32'hFF);
        for (int v = 0; v < NV; v++) begin
            int p;
            logic [2:0] m;
            p = v % IRQ_W;
            m = VEC[v][5:3];
            wr(C, 0);
            @(negedge clk) pins_in[IRQ_W-1:0] = 8'(VEC[v][2]) << p;
            repeat (5) @(posedge clk);
            wr(C, 32'(m) << (3 * p));
            repeat (5) @(posedge clk);
            wr(C + 3, 32'hFF);
            @(negedge clk) pins_in[IRQ_W-1:0] = 8'(VEC[v][1]) << p;
            repeat (6) @(posedge clk);
            rdreg(C + 2, rd);
            check(tag_of(m), rd, 32'(VEC[v][0]) << p);
            check("R13 irq vs table", 32'(irq), 32'(VEC[v][0]));
        end
        wr(C, 0);
        pins_in[IRQ_W-1:0] = '0;
        repeat (4) @(posedge clk);
        wr(C + 3, 32'hFF);

        // R11 / R10 / R13: mask hides irq, pending kept
        wr(C + 1, 0);
        wr(C, 32'(4) << 6);
        @(negedge clk) pins_in[2] = 1'b1;
        repeat (5) @(posedge clk);
        rdreg(C + 2, rd);  check("R11 stat masked off", rd, 0);
        check("R11 irq masked off", 32'(irq), 0);
        wr(C + 1, 32'h04);
        check("R13 irq not yet", 32'(irq), 0);
        @(posedge clk); #1 check("R13 irq one cycle later", 32'(irq), 1);
        rdreg(C + 2, rd);  check("R11 pending kept", rd, 32'h04);
        rdreg(C + 1, rd);  check("R10 mask readback", rd, 32'h04);

        // R12: write-one acknowledge
        wr(C + 3, 0);
        rdreg(C + 2, rd);  check("R12 zero ack", rd, 32'h04);
        wr(C + 3, 32'hFB);
        rdreg(C + 2, rd);  check("R12 other bits ack", rd, 32'h04);
        wr(C + 3, 32'h04);
        check("R13 irq lags ack", 32'(irq), 1);
        rdreg(C + 2, rd);  check("R12 ack clears", rd, 0);
        check("R13 irq drops", 32'(irq), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule